// File: doc/BRIEF.md
# I2S Transmit Master with Programmable Bit-Clock Ratio

This block is the transmit side of an I2S master. From a fast system clock it derives the serial bit clock and the left/right word-select clock. It then sends a stereo sample pair, most significant bit first, on the serial data line.

The bit-clock half-period is set by an 8-bit ratio plus a fixed offset of two system cycles. Each channel word carries a programmable number of bits, and word select runs at the bit rate divided by twice that count. For example, a 50 MHz system clock with a 20-bit word and a 48 kHz frame rate calls for a 1.92 Mb/s bit clock.

Samples are offered on a parallel pair with a valid flag. The block raises a one-cycle request, which also acts as its ready, at the point where it takes the next pair. If no pair is valid at that point, the block sends a silent frame and the clocks keep running.

Top module: `i2s_tx_master`

## Requirements
- R1: While `enable_i` is low or `rst_ni` is low, `sck_o`, `ws_o`, `sd_o` and `req_o` are low, and the block restarts from its initial state when enabled again.
- R2: `sck_o` starts low, first rises `ratio_i`+2 system cycles after the first clock edge with `enable_i` high, and has a period of 2×(`ratio_i`+2) system cycles.
- R3: `ws_o` is 0 while the left word is sent and 1 while the right word is sent. It changes on the SCK falling edge that starts the last bit of the preceding word, one SCK period ahead of the MSB.
- R4: `sd_o` changes only on SCK falling edges and carries bits [RES-1:0] of each sample, MSB first, with RES bits per channel.
- R5: `req_o` is high for exactly one system cycle, while `sck_o` is high, in the cycle before the falling edge that begins a left word. The pair on `left_i`/`right_i` is taken in that cycle if `valid_i` is high.
- R6: If `valid_i` is low in the `req_o` cycle, both words of that frame are sent as zeros and SCK/WS keep running.
- R7: The resolution `res_i` is clamped to the range 8..32. A value below 8 acts as 8 and a value above 32 acts as 32.
- R8: Changes to `ratio_i` or `res_i` take effect only at the next left-frame boundary (the `req_o` cycle). The frame in progress keeps its settings.
- R9: After enable, the first SCK bit slot is a lead-in with `ws_o`=0 and `sd_o`=0. The left MSB of the first frame is on the second SCK rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the clocks and the transmitter when high |
| ratio_i | input | 8 | Bit-clock ratio; SCK half-period is ratio_i+2 cycles |
| res_i | input | 6 | Bits per channel word, clamped to 8..32 |
| left_i | input | 32 | Left sample, right-aligned in bits [RES-1:0] |
| right_i | input | 32 | Right sample, right-aligned in bits [RES-1:0] |
| valid_i | input | 1 | Sample pair on left_i/right_i is valid |
| req_o | output | 1 | One-cycle request/ready: pair is taken in this cycle |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select: 0 left, 1 right |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
The assertions assume that `rst_ni` is the only asynchronous input and that all other inputs are synchronous to `clk_i`. They do not depend on `valid_i` or on the sample data. They assume `ratio_i` fits its 8 bits, which bounds every SCK half-period at 257 cycles.

The stimulus changes inputs only at falling system-clock edges. It changes `ratio_i` and `res_i` only while the block is disabled, or right after a request, to exercise the frame-boundary rule. It uses `res_i` values both inside and outside the 8..32 range.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int unsigned RATIO_W_DEF  = 8;
  localparam int unsigned RES_W_DEF    = 6;
  localparam int unsigned SAMPLE_W_DEF = 32;
  localparam int unsigned RES_MIN      = 8;
  localparam int unsigned RATIO_OFFSET = 2;
endpackage

// File: rtl/i2s_clk_div.sv
module i2s_clk_div #(
  parameter int unsigned RATIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               sck_o,
  output logic               fall_o
);
  localparam int unsigned DIV_W = RATIO_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] term;
  logic             sck_q;
  logic             tick;

  // half-period = ratio + offset cycles; terminal count is one less
  assign term = {1'b0, ratio_i} + DIV_W'(i2s_tx_pkg::RATIO_OFFSET - 1);
  assign tick = (div_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (!en_i) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign sck_o  = sck_q;
  assign fall_o = en_i & sck_q & tick;
endmodule

// File: rtl/i2s_frame_ctl.sv
module i2s_frame_ctl #(
  parameter int unsigned RATIO_W  = 8,
  parameter int unsigned RES_W    = 6,
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               fall_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RES_W-1:0]   res_i,
  output logic [RATIO_W-1:0] ratio_s_o,
  output logic [RES_W-1:0]   res_s_o,
  output logic [RES_W-1:0]   res_in_o,
  output logic               ws_o,
  output logic               frame_start_o,
  output logic               right_start_o
);
  localparam logic [RES_W-1:0] RES_LO = RES_W'(i2s_tx_pkg::RES_MIN);
  localparam logic [RES_W-1:0] RES_HI = RES_W'(SAMPLE_W);

  logic [RATIO_W-1:0] ratio_s_q;
  logic [RES_W-1:0]   res_s_q;
  logic [RES_W-1:0]   res_c;
  logic [RES_W-1:0]   k_q;
  logic [RES_W-1:0]   k_nxt;
  logic               ch_q;
  logic               ws_q;
  logic               last;

  always_comb begin
    if (res_i < RES_LO)      res_c = RES_LO;
    else if (res_i > RES_HI) res_c = RES_HI;
    else                     res_c = res_i;
  end

  assign last          = (k_q == res_s_q - 1'b1);
  assign k_nxt         = k_q + 1'b1;
  assign frame_start_o = fall_i & ch_q & last;
  assign right_start_o = fall_i & ~ch_q & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_s_q <= '0;
      res_s_q   <= RES_LO;
      k_q       <= RES_LO - 1'b1;
      ch_q      <= 1'b1;
      ws_q      <= 1'b0;
    end else if (!en_i) begin
      // idle: sit in the last slot of a right word so the first slot is a lead-in
      ratio_s_q <= ratio_i;
      res_s_q   <= res_c;
      k_q       <= res_c - 1'b1;
      ch_q      <= 1'b1;
      ws_q      <= 1'b0;
    end else if (fall_i) begin
      if (last) begin
        k_q  <= '0;
        ch_q <= ~ch_q;
        ws_q <= ~ch_q;
        if (ch_q) begin
          ratio_s_q <= ratio_i;
          res_s_q   <= res_c;
        end
      end else begin
        k_q  <= k_nxt;
        ws_q <= (k_nxt == res_s_q - 1'b1) ? ~ch_q : ch_q;
      end
    end
  end

  assign ratio_s_o = ratio_s_q;
  assign res_s_o   = res_s_q;
  assign res_in_o  = res_c;
  assign ws_o      = ws_q;
endmodule

// File: rtl/i2s_shifter.sv
module i2s_shifter #(
  parameter int unsigned RES_W    = 6,
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                fall_i,
  input  logic                frame_start_i,
  input  logic                right_start_i,
  input  logic                take_i,
  input  logic [RES_W-1:0]    res_new_i,
  input  logic [RES_W-1:0]    res_cur_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sd_o
);
  localparam logic [RES_W-1:0] W_L = RES_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] sh_q;
  logic [SAMPLE_W-1:0] hold_q;
  logic [RES_W-1:0]    amt_new;
  logic [RES_W-1:0]    amt_cur;

  // left-align the RES-bit word so the MSB sits at the top
  assign amt_new = W_L - res_new_i;
  assign amt_cur = W_L - res_cur_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      hold_q <= '0;
    end else if (!en_i) begin
      sh_q   <= '0;
      hold_q <= '0;
    end else if (frame_start_i) begin
      sh_q   <= take_i ? (left_i << amt_new) : '0;
      hold_q <= take_i ? right_i : '0;
    end else if (right_start_i) begin
      sh_q   <= hold_q << amt_cur;
    end else if (fall_i) begin
      sh_q   <= {sh_q[SAMPLE_W-2:0], 1'b0};
    end
  end

  assign sd_o = sh_q[SAMPLE_W-1];
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
  parameter int unsigned RATIO_W  = i2s_tx_pkg::RATIO_W_DEF,
  parameter int unsigned RES_W    = i2s_tx_pkg::RES_W_DEF,
  parameter int unsigned SAMPLE_W = i2s_tx_pkg::SAMPLE_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [RATIO_W-1:0]  ratio_i,
  input  logic [RES_W-1:0]    res_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                valid_i,
  output logic                req_o,
  output logic                sck_o,
  output logic                ws_o,
  output logic                sd_o
);
  logic [RATIO_W-1:0] ratio_s;
  logic [RES_W-1:0]   res_s;
  logic [RES_W-1:0]   res_in;
  logic               fall;
  logic               frame_start;
  logic               right_start;

  i2s_clk_div #(.RATIO_W(RATIO_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enable_i),
    .ratio_i (ratio_s),
    .sck_o   (sck_o),
    .fall_o  (fall)
  );

  i2s_frame_ctl #(.RATIO_W(RATIO_W), .RES_W(RES_W), .SAMPLE_W(SAMPLE_W)) u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (enable_i),
    .fall_i        (fall),
    .ratio_i       (ratio_i),
    .res_i         (res_i),
    .ratio_s_o     (ratio_s),
    .res_s_o       (res_s),
    .res_in_o      (res_in),
    .ws_o          (ws_o),
    .frame_start_o (frame_start),
    .right_start_o (right_start)
  );

  i2s_shifter #(.RES_W(RES_W), .SAMPLE_W(SAMPLE_W)) u_sh (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (enable_i),
    .fall_i        (fall),
    .frame_start_i (frame_start),
    .right_start_i (right_start),
    .take_i        (valid_i),
    .res_new_i     (res_in),
    .res_cur_i     (res_s),
    .left_i        (left_i),
    .right_i       (right_i),
    .sd_o          (sd_o)
  );

  assign req_o = frame_start;
endmodule

// File: rtl/i2s_tx_master_chk.sv
module i2s_tx_master_chk #(
  parameter int unsigned RATIO_W = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic req_o,
  input logic sck_o,
  input logic ws_o,
  input logic sd_o
);
  localparam int unsigned CNT_W    = RATIO_W + 2;
  localparam int unsigned HALF_MAX = (1 << RATIO_W) + 1;

  logic [CNT_W-1:0] lvl_cnt;
  logic             sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_cnt <= '0;
      sck_d   <= 1'b0;
    end else begin
      sck_d <= sck_o;
      if (!enable_i || (sck_o != sck_d)) lvl_cnt <= '0;
      else if (lvl_cnt != '1)            lvl_cnt <= lvl_cnt + 1'b1;
    end
  end

  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!sck_o && !ws_o && !sd_o && !req_o));

  a_r2_half_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_cnt < CNT_W'(HALF_MAX));

  a_r3_ws_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(ws_o));

  a_r4_sd_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(sd_o));

  a_r5_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  a_r5_req_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> sck_o);

  a_r5_req_then_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && enable_i) |=> !sck_o);
endmodule

bind i2s_tx_master i2s_tx_master_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .req_o    (req_o),
  .sck_o    (sck_o),
  .ws_o     (ws_o),
  .sd_o     (sd_o)
);

// File: tb/i2s_tx_master_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_master_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic [7:0]  ratio_i = '0;
  logic [5:0]  res_i = 6'd16;
  logic [31:0] left_i = '0;
  logic [31:0] right_i = '0;
  logic        valid_i = 1'b0;
  logic        req_o, sck_o, ws_o, sd_o;

  int n_chk = 0;
  int n_bad = 0;

  // {valid, left, right}
  localparam int NV = 6;
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 32'h0000_A5C3, 32'h0000_3C81},
    {1'b1, 32'hFFFF_8001, 32'h1234_7FFE},
    {1'b0, 32'h0000_FFFF, 32'h0000_FFFF},
    {1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    {1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b1, 32'h8000_0001, 32'h5555_AAAA}
  };

  logic cap_ws [256];
  logic cap_sd [256];
  int   cap_t  [256];
  int   n_req;
  int   req_dbl;

  always #2 clk_i = ~clk_i;

  i2s_tx_master dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .ratio_i(ratio_i),
    .res_i(res_i), .left_i(left_i), .right_i(right_i), .valid_i(valid_i),
    .req_o(req_o), .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clampr(input int r);
    if (r < 8) return 8;
    if (r > 32) return 32;
    return r;
  endfunction

  task automatic drive_vec(input int i);
    valid_i = VEC[i][64];
    left_i  = VEC[i][63:32];
    right_i = VEC[i][31:0];
  endtask

  // run nfr frames from vector base; optional ratio/res change after first request
  task automatic run(input int base, input int nfr, input int rat, input int rs,
                     input bit chg, input int rat2, input int rs2);
    int need, rc, cyc, idx;
    bit pend, prev_sck, prev_req;
    need = 1 + 2 * clampr(rs) + (nfr - 1) * 2 * clampr(chg ? rs2 : rs);
    @(negedge clk_i);
    enable_i = 1'b0;
    ratio_i = 8'(rat);
    res_i = 6'(rs);
    idx = base;
    drive_vec(idx);
    repeat (3) @(negedge clk_i);
    enable_i = 1'b1;
    rc = 0; cyc = 0; pend = 0; prev_sck = 0; prev_req = 0;
    n_req = 0; req_dbl = 0;
    while (rc < need && cyc < 20000) begin
      @(negedge clk_i);
      cyc++;
      if (pend) begin
        idx++;
        if (idx < NV) drive_vec(idx);
        if (chg && n_req == 1) begin
          ratio_i = 8'(rat2);
          res_i = 6'(rs2);
        end
        pend = 0;
      end
      if (req_o) begin
        pend = 1;
        n_req++;
        if (prev_req) req_dbl++;
      end
      prev_req = req_o;
      if (!prev_sck && sck_o) begin
        cap_ws[rc] = ws_o;
        cap_sd[rc] = sd_o;
        cap_t[rc] = cyc;
        rc++;
      end
      prev_sck = sck_o;
    end
  endtask

  task automatic cmp(input int base, input int nfr, input int rs0, input int rs1);
    int r, res;
    logic [31:0] gl, gr, el, er, wl, wr, ewl, ewr, m;
    chk("R9 lead-in ws/sd", {30'd0, cap_ws[0], cap_sd[0]}, 32'd0);
    r = 1;
    for (int f = 0; f < nfr; f++) begin
      res = clampr(f == 0 ? rs0 : rs1);
      m = (res == 32) ? 32'hFFFF_FFFF : ((32'd1 << res) - 1);
      el = VEC[base + f][64] ? (VEC[base + f][63:32] & m) : 32'd0;
      er = VEC[base + f][64] ? (VEC[base + f][31:0] & m) : 32'd0;
      gl = '0; gr = '0; wl = '0; wr = '0;
      for (int k = 0; k < res; k++) begin
        gl = {gl[30:0], cap_sd[r + k]};
        wl = {wl[30:0], cap_ws[r + k]};
      end
      r += res;
      for (int k = 0; k < res; k++) begin
        gr = {gr[30:0], cap_sd[r + k]};
        wr = {wr[30:0], cap_ws[r + k]};
      end
      r += res;
      ewl = 32'd1;
      ewr = m & ~32'd1;
      if (VEC[base + f][64]) begin
        chk("R4 left word", gl, el);
        chk("R4 right word", gr, er);
      end else begin
        chk("R6 left silent", gl, el);
        chk("R6 right silent", gr, er);
      end
      chk("R3 left ws pattern", wl, ewl);
      chk("R3 right ws pattern", wr, ewr);
    end
    chk("R5 one request per frame", 32'(n_req), 32'(nfr));
    chk("R5 request single-cycle", 32'(req_dbl), 32'd0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", {28'd0, req_o, sck_o, ws_o, sd_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R1 disabled outputs", {28'd0, req_o, sck_o, ws_o, sd_o}, 32'd0);

    // table walk: all vectors, 16-bit words, ratio 1
    run(0, NV, 1, 16, 0, 0, 0);
    cmp(0, NV, 16, 16);
    chk("R2 first rise", 32'(cap_t[0]), 32'd3);
    chk("R2 sck period", 32'(cap_t[1] - cap_t[0]), 32'd6);

    // R7: resolution below range acts as 8, ratio 0
    run(0, 3, 0, 4, 0, 0, 0);
    cmp(0, 3, 4, 4);
    chk("R2 period ratio0", 32'(cap_t[5] - cap_t[4]), 32'd4);

    // R7: resolution above range acts as 32
    run(3, 2, 3, 40, 0, 0, 0);
    cmp(3, 2, 40, 40);
    chk("R2 period ratio3", 32'(cap_t[9] - cap_t[8]), 32'd10);

    // R8: change mid-frame takes effect at the next left boundary
    run(0, 3, 1, 8, 1, 4, 12);
    cmp(0, 3, 8, 12);
    chk("R8 old ratio kept in frame", 32'(cap_t[16] - cap_t[15]), 32'd6);
    chk("R8 new ratio after boundary", 32'(cap_t[18] - cap_t[17]), 32'd12);

    // R1: disable mid-stream
    enable_i = 1'b1;
    repeat (30) @(negedge clk_i);
    enable_i = 1'b0;
    @(negedge clk_i);
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        if (req_o | sck_o | ws_o | sd_o) bad++;
        @(negedge clk_i);
      end
      chk("R1 low while disabled", 32'(bad), 32'd0);
    end

    // R1: asynchronous reset mid-stream
    enable_i = 1'b1;
    ratio_i = 8'd0;
    repeat (37) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset outputs", {28'd0, req_o, sck_o, ws_o, sd_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    enable_i = 1'b0;
    repeat (2) @(negedge clk_i);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule